// File: doc/BRIEF.md
# Non-maskable interrupt source and mask controller

This block turns two active-low error inputs into one non-maskable interrupt request for a processor. The inputs are a bus system-error line and an I/O channel-check line. Each source has a sticky pending bit. The pending bit is set by the falling edge of its input, and only while that source's disable bit is 0. Setting the disable bit to 1 clears the pending bit and keeps it clear. A separate global mask bit, held in a second register, blocks the output while it is 1.

Software reads the control register to find which source is pending. It acknowledges an event by writing that source's disable bit to 1, and it re-arms the source by writing the bit back to 0.

The processor only sees a rising edge, so an output state machine drives the request. Its states are:

- `NMI_IDLE`: the output is low. The machine moves to `NMI_ACTIVE` when a pending, enabled source exists and the mask is 0.
- `NMI_ACTIVE`: the output is high. The machine moves to `NMI_REARM` when that condition goes away.
- `NMI_REARM`: the output is low for a guaranteed gap. The machine returns to `NMI_IDLE` when the gap counter expires.

Each source tracker has its own two-state machine, `SRC_CLEAR` and `SRC_PENDING`:

- It moves from clear to pending on an input falling edge while enabled.
- It moves from pending to clear while its disable bit is 1.

Register port: `reg_sel` = 0 selects the control register and `reg_sel` = 1 selects the mask register. A write happens on a clock edge with `wr_en` high. Reads are combinational through `rdata`.

Control register layout:

| Bit | Access | Meaning |
|-----|--------|---------|
| 7 | read-only | pending bit, system-error source |
| 6 | read-only | pending bit, channel-check source |
| 3 | read/write | disable bit, channel-check source |
| 2 | read/write | disable bit, system-error source |

Mask register layout: bit 7 is the global mask.

Top module: `nmi_source_ctl`

## Requirements
- R1: After reset `nmi` is 0, the control register reads 0x0C (both disables 1, no pending) and the mask register reads 0x80.
- R2: A falling edge on `sys_err_n` while control bit 2 is 0 sets control bit 7 at that clock edge. The bit then stays set after the input returns high, until it is cleared.
- R3: A falling edge on `chan_chk_n` while control bit 3 is 0 sets control bit 6 at that clock edge. The bit then stays set after the input returns high, until it is cleared.
- R4: While a source's disable bit is 1, a falling edge or a held-low level on its input leaves its pending bit at 0 and `nmi` at 0.
- R5: A write of 1 to a source's disable bit clears that source's pending bit at the same clock edge.
- R6: With the mask at 0 and the source enabled, `nmi` goes high at the second clock edge after the input falls.
- R7: While the mask bit is 1, `nmi` stays low even with pending sources. The pending bits are kept.
- R8: `nmi` goes low one clock edge after the last pending enabled source is cleared or after the mask is set. It stays high while any other enabled source is still pending.
- R9: Once `nmi` falls, it stays low for at least LOW_GAP + 1 clock cycles before it can rise again.
- R10: An input held low does not set its pending bit again after a clear and re-enable. Only a new falling edge sets it.
- R11: Control bits 5:4 and 1:0, and mask bits 6:0, read as 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_err_n | input | 1 | Bus system-error input, active low |
| chan_chk_n | input | 1 | I/O channel-check input, active low |
| reg_sel | input | 1 | Register select: 0 control, 1 mask |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| nmi | output | 1 | Non-maskable interrupt request, active high |

## Verification
The bench builds the block with the default LOW_GAP of 2. It measures the rearm gap exactly: the mask is cleared while the gap counter is still running, and the bench checks that `nmi` returns only after three low cycles. With this value, every edge-to-output latency and every clear-to-drop latency fits in a few hand-counted cycles. The bench also keeps an input held low across a clear and re-enable, which is the case that separates edge capture from level capture.

// File: rtl/nmi_src_pkg.sv
package nmi_src_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned NUM_SRC  = 2;
    localparam int unsigned STAT_TOP = 7;   // source i pending at bit STAT_TOP - i
    localparam int unsigned DIS_LSB  = 2;   // source i disable at bit DIS_LSB + i
    localparam int unsigned MASK_BIT = 7;

    typedef enum logic [1:0] {
        NMI_IDLE,
        NMI_ACTIVE,
        NMI_REARM
    } nmi_state_e;

    typedef enum logic {
        SRC_CLEAR,
        SRC_PENDING
    } src_state_e;

endpackage

// File: rtl/nmi_src_latch.sv
module nmi_src_latch
    import nmi_src_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_n,
    input  logic dis,
    input  logic clr,
    output logic pending
);

    src_state_e state_q, state_d;
    logic       in_q;
    logic       fell;

    assign fell = in_q & ~in_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_CLEAR;
            in_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            in_q    <= in_n;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_CLEAR:   if (fell && !dis && !clr) state_d = SRC_PENDING;
            SRC_PENDING: if (dis || clr)           state_d = SRC_CLEAR;
            default:     state_d = SRC_CLEAR;
        endcase
    end

    assign pending = (state_q == SRC_PENDING);

    // R2 / R3: an enabled falling edge captures the event
    p_capture_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_n) && !in_n && !dis && !clr) |=> pending);

    // R2 / R3: the pending bit holds until cleared
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !dis && !clr) |=> pending);

    // R5: a clear strobe empties the pending bit
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pending);

    // R4: a disabled source cannot become pending
    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dis && !pending) |=> !pending);

endmodule

// File: rtl/nmi_out_fsm.sv
module nmi_out_fsm
    import nmi_src_pkg::*;
#(
    parameter int unsigned LOW_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic nmi
);

    localparam int unsigned CNT_W = $clog2(LOW_GAP + 1) + 1;

    nmi_state_e       state_q, state_d;
    logic [CNT_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= NMI_IDLE;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == NMI_ACTIVE && state_d == NMI_REARM)
                gap_q <= CNT_W'(LOW_GAP - 1);
            else if (state_q == NMI_REARM && gap_q != '0)
                gap_q <= gap_q - 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NMI_IDLE:   if (req)          state_d = NMI_ACTIVE;
            NMI_ACTIVE: if (!req)         state_d = NMI_REARM;
            NMI_REARM:  if (gap_q == '0)  state_d = NMI_IDLE;
            default:    state_d = NMI_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nmi <= 1'b0;
        else        nmi <= (state_d == NMI_ACTIVE);
    end

    // R9: a falling output is followed by at least one more low cycle
    p_low_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi) |=> !nmi);

    // R6: a rise is always preceded by a request
    p_rise_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |-> $past(req));

endmodule

// File: rtl/nmi_source_ctl.sv
module nmi_source_ctl
    import nmi_src_pkg::*;
#(
    parameter int unsigned LOW_GAP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_err_n,
    input  logic             chan_chk_n,
    input  logic             reg_sel,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             nmi
);

    logic [NUM_SRC-1:0] dis_q;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] pending;
    logic [NUM_SRC-1:0] src_in_n;
    logic               mask_q;
    logic               req;
    logic               wr_ctl;
    logic               wr_mask;

    assign src_in_n = {chan_chk_n, sys_err_n};
    assign wr_ctl   = wr_en && !reg_sel;
    assign wr_mask  = wr_en && reg_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dis_q  <= '1;
            mask_q <= 1'b1;
        end else begin
            if (wr_ctl)  dis_q  <= wdata[DIS_LSB +: NUM_SRC];
            if (wr_mask) mask_q <= wdata[MASK_BIT];
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign clr[i] = wr_ctl && wdata[DIS_LSB + i];

        nmi_src_latch u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_n    (src_in_n[i]),
            .dis     (dis_q[i]),
            .clr     (clr[i]),
            .pending (pending[i])
        );
    end

    assign req = |(pending & ~dis_q) && !mask_q;

    always_comb begin
        rdata = '0;
        if (reg_sel) begin
            rdata[MASK_BIT] = mask_q;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                rdata[STAT_TOP - i] = pending[i];
                rdata[DIS_LSB + i]  = dis_q[i];
            end
        end
    end

    nmi_out_fsm #(.LOW_GAP(LOW_GAP)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .nmi   (nmi)
    );

    // R7: the mask blocks the output
    p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |=> !nmi);

    // R8: with nothing pending and enabled, the output drops
    p_drop_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pending & ~dis_q)) |=> !nmi);

endmodule

// File: tb/nmi_source_ctl_test.sv
module nmi_source_ctl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_err_n = 1'b1;
    logic       chan_chk_n = 1'b1;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       nmi;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        bit         is_nmi;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t exp_q[$];
    event  pushed, compared;

    always #5 clk = ~clk;

    nmi_source_ctl #(.LOW_GAP(2)) uut (
        .clk(clk), .rst_n(rst_n), .sys_err_n(sys_err_n), .chan_chk_n(chan_chk_n),
        .reg_sel(reg_sel), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .nmi(nmi)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(pushed);
            #1;
            while (exp_q.size() != 0) begin
                item_t it;
                logic [7:0] act;
                it = exp_q.pop_front();
                act = it.is_nmi ? {7'b0, nmi} : rdata;
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
                end
            end
            ->compared;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic exp_nmi(input logic v, input string tag);
        item_t it;
        it.is_nmi = 1'b1; it.exp = {7'b0, v}; it.tag = tag;
        exp_q.push_back(it);
        ->pushed;
        @(compared);
    endtask

    task automatic exp_rd(input logic sel, input logic [7:0] v, input string tag);
        item_t it;
        reg_sel = sel;
        it.is_nmi = 1'b0; it.exp = v; it.tag = tag;
        exp_q.push_back(it);
        ->pushed;
        @(compared);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_sel = sel; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        exp_nmi(1'b0, "R1 nmi low after reset");
        exp_rd(1'b0, 8'h0C, "R1 control reset value");
        exp_rd(1'b1, 8'h80, "R1 mask reset value");

        // R4: disabled source ignores edge and level
        tick();
        sys_err_n = 1'b0;
        tick(); tick();
        exp_rd(1'b0, 8'h0C, "R4 disabled source not pending");
        exp_nmi(1'b0, "R4 nmi low while disabled");
        tick();
        sys_err_n = 1'b1;
        tick();

        wr(1'b0, 8'h00);
        wr(1'b1, 8'h00);
        exp_nmi(1'b0, "R4 nothing pending after enable");

        // R2 / R6
        tick();
        sys_err_n = 1'b0;
        tick();
        exp_rd(1'b0, 8'h80, "R2 pending set on edge");
        exp_nmi(1'b0, "R6 nmi still low after first edge");
        tick();
        exp_nmi(1'b1, "R6 nmi high at second edge");
        sys_err_n = 1'b1;
        tick();
        exp_rd(1'b0, 8'h80, "R2 sticky after input release");
        exp_nmi(1'b1, "R2 nmi held");

        // R5 / R8
        tick();
        wr(1'b0, 8'h04);
        exp_rd(1'b0, 8'h04, "R5 clear on disable write");
        exp_nmi(1'b1, "R8 nmi drops only one edge later");
        tick();
        exp_nmi(1'b0, "R8 nmi low after clear");
        wr(1'b0, 8'h00);

        // R3 / R7 / R9
        repeat (4) tick();
        chan_chk_n = 1'b0;
        tick();
        exp_rd(1'b0, 8'h40, "R3 channel-check pending");
        tick();
        exp_nmi(1'b1, "R6 nmi from channel check");
        wr(1'b1, 8'h80);
        exp_nmi(1'b1, "R8 mask takes one edge");
        tick();
        exp_nmi(1'b0, "R7 masked nmi low");
        exp_rd(1'b0, 8'h40, "R7 pending kept under mask");
        wr(1'b1, 8'h00);
        exp_nmi(1'b0, "R9 gap cycle 1");
        tick();
        exp_nmi(1'b0, "R9 gap cycle 2");
        tick();
        exp_nmi(1'b1, "R9 nmi returns after gap");

        // R10: held-low input does not re-trigger
        wr(1'b0, 8'h08);
        exp_rd(1'b0, 8'h08, "R5 channel-check cleared");
        tick();
        exp_nmi(1'b0, "R8 nmi low after channel clear");
        wr(1'b0, 8'h00);
        tick(); tick();
        exp_rd(1'b0, 8'h00, "R10 held level not recaptured");
        exp_nmi(1'b0, "R10 nmi stays low");
        chan_chk_n = 1'b1;
        tick();
        chan_chk_n = 1'b0;
        tick();
        exp_rd(1'b0, 8'h40, "R10 new edge captured");
        tick();
        exp_nmi(1'b1, "R10 nmi after new edge");

        // R8: another source still pending keeps nmi high
        sys_err_n = 1'b0;
        tick();
        exp_rd(1'b0, 8'hC0, "R2 both sources pending");
        wr(1'b0, 8'h04);
        exp_rd(1'b0, 8'h44, "R5 only system-error cleared");
        tick();
        exp_nmi(1'b1, "R8 nmi held by remaining source");

        // R11
        wr(1'b0, 8'hFF);
        exp_rd(1'b0, 8'h0C, "R11 control unused bits read 0");
        wr(1'b1, 8'hFF);
        exp_rd(1'b1, 8'h80, "R11 mask unused bits read 0");
        tick();
        exp_nmi(1'b0, "R7 nmi low when all off");

        sys_err_n = 1'b1;
        chan_chk_n = 1'b1;
        tick();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule